// File: doc/BRIEF.md
# Interrupt Enable Mask Bank

This block decides which of a peripheral's interrupt sources may drive the shared interrupt line. Software never writes the enable state directly. A write to the enable port turns on each source whose data bit is 1. A write to the disable port turns off each source whose data bit is 1. A separate read-only mask view reports the result, with a 1 for each source that is currently blocked.

Each source also delivers one-cycle event pulses. Each pulse sets a sticky status bit whether or not that source is enabled. A read of the status address returns those bits and clears them. The single interrupt output is high while any source has both its status bit and its enable set.

The block sits behind a simple 32-bit register bus with a select, a write flag, a byte address and write data. Read data is combinational on the same cycle as the read strobe, and clearing takes effect at the clock edge that ends the read.

Top module: `irq_mask_bank`

## Requirements
- R1: While reset is asserted and after it is released, every source is disabled, the mask view reads 1 for every implemented source, every status bit is 0, and the interrupt output is low.
- R2: A bus write to byte offset 0x00 (enable port) enables each source whose write data bit is 1. Sources whose bit is 0 keep their enable state.
- R3: A bus write to byte offset 0x04 (disable port) disables each source whose write data bit is 1. Sources whose bit is 0 keep their enable state.
- R4: A read of byte offset 0x08 (mask view) returns bit n = 1 when source n is disabled and 0 when it is enabled. Bits at or above the source count read 0.
- R5: Writes to offset 0x08 and offset 0x0C change neither the enable state nor the status bits. Reads of offsets 0x00 and 0x04 return 0.
- R6: An event pulse on source n sets status bit n on the next clock edge, whatever the enable state of source n.
- R7: A read of byte offset 0x0C returns the status bits, with bits at or above the source count reading 0, and clears every status bit at the end of that cycle.
- R8: If an event pulse arrives in the same cycle as a status read, its status bit is set after the read, so the event stays pending.
- R9: The interrupt output is high exactly when some source has both its status bit set and its enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe for this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the cycle of the read |
| eventIn | input | NUM_SRC | One-cycle event pulses, one per source |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with 20 sources on the 32-bit bus. With that setting, bits 20 to 31 of each write have no source behind them, so the padding of the mask and status views with zeros can be observed. Writes of all ones to the enable port show that those unused bits stay at 0 in the mask view. A reference model of enables and status runs on random bus traffic and random event pulses. This reaches clears that coincide with new events, and sources that fire while disabled and are enabled later.

// File: rtl/irq_mask_bank_pkg.sv
package irq_mask_bank_pkg;

  // Word index taken from address bits [3:2]
  localparam logic [1:0] REG_ENABLE  = 2'd0;
  localparam logic [1:0] REG_DISABLE = 2'd1;
  localparam logic [1:0] REG_MASK    = 2'd2;
  localparam logic [1:0] REG_STATUS  = 2'd3;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_MASK   = 2'd1,
    RD_STATUS = 2'd2
  } readSel_e;

  typedef struct packed {
    logic     setEn;     // write-one-to-enable
    logic     clrEn;     // write-one-to-disable
    logic     rdStatus;  // status read, clears on this edge
    readSel_e rdSel;     // which view drives read data
  } ctrlStrobe_t;

endpackage

// File: rtl/irq_mask_bank_ctrl.sv
module irq_mask_bank_ctrl
  import irq_mask_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobe_t       strobe
);

  logic       inRange;
  logic [1:0] wordIdx;

  generate
    if (ADDR_W > 4) begin : g_wideAddr
      assign inRange = (busAddr[ADDR_W-1:4] == '0);
    end else begin : g_narrowAddr
      assign inRange = 1'b1;
    end
  endgenerate

  assign wordIdx = busAddr[3:2];

  always_comb begin
    strobe = '{setEn: 1'b0, clrEn: 1'b0, rdStatus: 1'b0, rdSel: RD_NONE};
    if (busSel && inRange) begin
      if (busWrite) begin
        strobe.setEn = (wordIdx == REG_ENABLE);
        strobe.clrEn = (wordIdx == REG_DISABLE);
      end else begin
        case (wordIdx)
          REG_MASK:   strobe.rdSel = RD_MASK;
          REG_STATUS: begin
            strobe.rdSel    = RD_STATUS;
            strobe.rdStatus = 1'b1;
          end
          default:    strobe.rdSel = RD_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_mask_bank_datapath.sv
module irq_mask_bank_datapath
  import irq_mask_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] enableVec,
  output logic [NUM_SRC-1:0] statusVec
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] setBits;
  logic [NUM_SRC-1:0] clrBits;
  logic [DATA_W-1:0]  maskWide;
  logic [DATA_W-1:0]  statusWide;

  assign setBits = strobe.setEn ? wdata[NUM_SRC-1:0] : '0;
  assign clrBits = strobe.clrEn ? wdata[NUM_SRC-1:0] : '0;

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_src
      // Disable takes priority over enable for the same bit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enableVec[i] <= 1'b0;
        end else if (clrBits[i]) begin
          enableVec[i] <= 1'b0;
        end else if (setBits[i]) begin
          enableVec[i] <= 1'b1;
        end
      end

      // A new event outranks the clear from a coinciding read
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statusVec[i] <= 1'b0;
        end else if (eventIn[i]) begin
          statusVec[i] <= 1'b1;
        end else if (strobe.rdStatus) begin
          statusVec[i] <= 1'b0;
        end
      end
    end

    if (PAD_W > 0) begin : g_pad
      assign maskWide   = {{PAD_W{1'b0}}, ~enableVec};
      assign statusWide = {{PAD_W{1'b0}}, statusVec};
    end else begin : g_noPad
      assign maskWide   = ~enableVec;
      assign statusWide = statusVec;
    end
  endgenerate

  always_comb begin
    case (strobe.rdSel)
      RD_MASK:   rdata = maskWide;
      RD_STATUS: rdata = statusWide;
      default:   rdata = '0;
    endcase
  end

  assign irqOut = |(statusVec & enableVec);

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_mask_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] eventIn,
  output logic               irqOut
);

  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] enableVec;
  logic [NUM_SRC-1:0] statusVec;

  irq_mask_bank_ctrl #(
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  irq_mask_bank_datapath #(
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (busWdata),
    .eventIn  (eventIn),
    .rdata    (busRdata),
    .irqOut   (irqOut),
    .enableVec(enableVec),
    .statusVec(statusVec)
  );

endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] eventIn,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] enableVec,
  input logic [NUM_SRC-1:0] statusVec
);

  logic wrEnable, wrDisable, rdStatus;
  assign wrEnable  = busSel && busWrite  && (busAddr == ADDR_W'(0));
  assign wrDisable = busSel && busWrite  && (busAddr == ADDR_W'(4));
  assign rdStatus  = busSel && !busWrite && (busAddr == ADDR_W'(12));

  AST_RESET_CLEAN: assert property (@(posedge clk) !rstN |=> (enableVec == '0 && statusVec == '0)); // R1

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrEnable |=> ((enableVec & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0]))); // R2

  AST_DISABLE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    wrDisable |=> ((enableVec & $past(busWdata[NUM_SRC-1:0])) == '0)); // R3

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEnable && !wrDisable) |=> $stable(enableVec)); // R5

  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (eventIn != '0) |=> ((statusVec & $past(eventIn)) == $past(eventIn))); // R8

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |=> ((statusVec & ~$past(eventIn)) == '0)); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enableVec == '0) |-> !irqOut); // R9

endmodule

bind irq_mask_bank irq_mask_bank_chk #(
  .DATA_W (DATA_W),
  .NUM_SRC(NUM_SRC),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .eventIn  (eventIn),
  .irqOut   (irqOut),
  .enableVec(enableVec),
  .statusVec(statusVec)
);

// File: tb/irq_mask_bank_test.sv
module irq_mask_bank_test;

  localparam int DW = 32;
  localparam int NS = 20;
  localparam int AW = 4;
  localparam logic [DW-1:0] IMPL = DW'((64'd1 << NS) - 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [NS-1:0] eventIn = '0;
  logic          irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [NS-1:0] mEn = '0;
  logic [NS-1:0] mSt = '0;

  always #10 clk = ~clk;

  irq_mask_bank #(.DATA_W(DW), .NUM_SRC(NS), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .eventIn(eventIn), .irqOut(irqOut)
  );

  function automatic logic [DW-1:0] expRead(input logic [AW-1:0] a);
    case (a)
      4'h8:    return {{(DW-NS){1'b0}}, ~mEn};
      4'hC:    return {{(DW-NS){1'b0}}, mSt};
      default: return '0;
    endcase
  endfunction

  function automatic string readReq(input logic [AW-1:0] a);
    case (a)
      4'h8:    return "R4";
      4'hC:    return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at falling edge, check before rising edge, update model after it
  task automatic step(input bit sel, input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [NS-1:0] ev);
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = a; busWdata = wd; eventIn = ev;
    #2;
    chk(irqOut == |(mSt & mEn), "R9", DW'(irqOut), DW'(|(mSt & mEn)));
    if (sel && !wr) chk(busRdata == expRead(a), readReq(a), busRdata, expRead(a));
    @(posedge clk);
    #1;
    if (sel && wr && a == 4'h0) mEn = mEn | wd[NS-1:0];
    if (sel && wr && a == 4'h4) mEn = mEn & ~wd[NS-1:0];
    if (sel && !wr && a == 4'hC) mSt = '0;
    mSt = mSt | ev;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b1, 1'b0, a, '0, '0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b1, 1'b1, a, d, '0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", '0, '0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(irqOut == 1'b0, "R1", DW'(irqOut), '0);
    rstN = 1'b1;
    // R1: reset state seen through the mask and status views
    rd(4'h8);
    chk(busRdata == IMPL, "R1", busRdata, IMPL);
    rd(4'hC);
    chk(busRdata == '0, "R1", busRdata, '0);
    // R2 and R4: enable some sources
    wr(4'h0, 32'h0000_0005);
    rd(4'h8);
    // R6: event on a disabled source sets status, no interrupt
    step(1'b0, 1'b0, '0, '0, NS'(32'h8));
    rd(4'hC);
    rd(4'hC);
    // R9: event on an enabled source raises the interrupt
    step(1'b0, 1'b0, '0, '0, NS'(32'h1));
    step(1'b0, 1'b0, '0, '0, '0);
    // R3: disabling the pending source drops the interrupt
    wr(4'h4, 32'h0000_0001);
    step(1'b0, 1'b0, '0, '0, '0);
    // R8: event during a status read survives the clear
    step(1'b1, 1'b0, 4'hC, '0, NS'(32'h4));
    rd(4'hC);
    // R5: writes to read-only views change nothing, write ports read 0
    step(1'b0, 1'b0, '0, '0, NS'(32'h2));
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h8);
    rd(4'h0);
    rd(4'h4);
    rd(4'hC);
    // R4: bits above the source count read 0 after enabling everything
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h8);
    chk(busRdata == '0, "R4", busRdata, '0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h8);
    chk(busRdata == IMPL, "R3", busRdata, IMPL);
    // Random traffic against the model (R2 R3 R6 R7 R8 R9)
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      logic [NS-1:0] ev;
      a  = AW'(($urandom() % 4) * 4);
      ev = (($urandom() % 4) == 0) ? NS'($urandom()) & NS'($urandom()) : '0;
      step(($urandom() % 3) != 0, $urandom() % 2 == 1, a, $urandom(), ev);
    end
    step(1'b0, 1'b0, '0, '0, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule